// File: doc/BRIEF.md
# Paired Double-to-Single Floating-Point Narrowing Stage

This block takes a 128-bit word carrying two IEEE 754 binary64 numbers and narrows each of them to binary32. The two lanes work independently and in parallel. Both narrowed values are packed into the low half of a 128-bit result, and the high half is always zero. A 2-bit control input, sampled together with the operands, selects the rounding direction that is applied whenever a value cannot be represented exactly.

The conversion is a single registered pipeline stage. An operand accepted with `in_valid` high produces its result one clock later, flagged by `out_valid`. Along with each result the stage reports five exception indications. Each one is the OR of the two lanes' conditions for that operation: invalid operation, denormal operand, overflow, underflow and inexact. The flags describe only the result they accompany. Masking, trapping and any accumulation across operations are left to the surrounding logic.

Top module: `narrow_pair_cvt`

## Requirements
- R1: The lower input double (bits 63:0) narrows into result bits 31:0, the upper input double (bits 127:64) narrows into result bits 63:32, and result bits 127:64 are always zero.
- R2: `out_valid` is `in_valid` delayed by one clock. The result and the flags change only on a clock where `in_valid` was high, and hold their value otherwise.
- R3: Inexact finite results are rounded according to `rnd_mode`: 00 to nearest with ties to even, 01 toward negative infinity, 10 toward positive infinity, 11 toward zero.
- R4: A NaN input gives the binary32 NaN {sign, 8'hFF, 1, mantissa bits 50:29}. When the input's quiet bit (mantissa bit 51) is 0, the invalid flag is set. A quiet NaN raises no flag.
- R5: A finite input whose rounded magnitude reaches 2^128 sets overflow and inexact. The result is infinity for round-to-nearest, and for a rounding direction that points away from zero for that sign. Otherwise it is the largest finite binary32 (7F7FFFFF with the sign).
- R6: A value below 2^-126 before rounding is tiny. It is delivered as a correctly rounded binary32 subnormal, or as the smallest normal if rounding carries up to it. Underflow is set exactly when the value is tiny and inexact.
- R7: A subnormal binary64 input (exponent zero, mantissa nonzero) sets the denormal flag.
- R8: Signed zeros and infinities are passed through with their sign and raise no flag.
- R9: The inexact flag is set whenever the delivered finite or overflow result differs from the exact input value.
- R10: Each flag is the OR of the two lanes' conditions for the same operation.
- R11: During and just after reset, `out_valid`, the result and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and rounding control present this cycle |
| in_pair | input | 128 | Two binary64 operands, lane 0 in bits 63:0 |
| rnd_mode | input | 2 | Rounding direction for this operation |
| out_valid | output | 1 | Result registered from an accepted operation |
| out_pair | output | 128 | Two binary32 results in bits 63:0, zero above |
| flag_invalid | output | 1 | Signaling NaN seen in either lane |
| flag_denorm | output | 1 | Subnormal binary64 operand in either lane |
| flag_overflow | output | 1 | Either lane overflowed binary32 range |
| flag_underflow | output | 1 | Either lane was tiny and inexact |
| flag_inexact | output | 1 | Either lane was rounded |

## Verification
Two narrow boundaries are hard to reach from the ports. One is a value whose mantissa rounds all the way up into the next binade, which creates an overflow from 2^128 minus half an ulp, or a normal result from a tiny input. The other is an exact halfway case, where only round-to-nearest-even separates the two neighbours. Uniform random doubles almost never land on either. The stimulus therefore draws exponents from a window around the binary32 range edges, forces the low 29 mantissa bits to the halfway pattern or to all ones in a share of vectors, and adds directed operands that sit exactly on each boundary under every rounding direction.

// File: rtl/narrow_pkg.sv
package narrow_pkg;

  localparam int DBL_W     = 64;
  localparam int SGL_W     = 32;
  localparam int DBL_EXP_W = 11;
  localparam int DBL_MAN_W = 52;
  localparam int SGL_MAN_W = 23;
  localparam int SIG_W     = DBL_MAN_W + 1;
  localparam int EXP_S_W   = 13;
  localparam int SH_W      = 6;
  localparam int BIAS_GAP  = 896;
  localparam int NORM_SH   = DBL_MAN_W - SGL_MAN_W;
  localparam int MAX_SH    = SIG_W + 2;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rnd_e;

  typedef enum logic [2:0] {
    K_ZERO,
    K_INF,
    K_QNAN,
    K_SNAN,
    K_FINITE
  } kind_e;

  typedef struct packed {
    logic inv;
    logic den;
    logic ovf;
    logic unf;
    logic pre;
  } flags_t;

  // decides whether the kept magnitude is bumped by one unit in the last place
  function automatic logic round_up(rnd_e mode, logic sign, logic lsb,
                                    logic rbit, logic sticky);
    logic lost;
    lost = rbit | sticky;
    case (mode)
      RND_NEAR: return rbit & (sticky | lsb);
      RND_DOWN: return lost & sign;
      RND_UP:   return lost & ~sign;
      default:  return 1'b0;
    endcase
  endfunction

  // true when an out-of-range magnitude saturates to infinity
  function automatic logic ovf_to_inf(rnd_e mode, logic sign);
    case (mode)
      RND_NEAR: return 1'b1;
      RND_DOWN: return sign;
      RND_UP:   return ~sign;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/narrow_unpack.sv
module narrow_unpack
  import narrow_pkg::*;
(
  input  logic [DBL_W-1:0]          dbl,
  output logic                      sign,
  output kind_e                     kind,
  output logic signed [EXP_S_W-1:0] es,
  output logic [SIG_W-1:0]          sig,
  output logic [SGL_MAN_W-2:0]      payload,
  output logic                      den_in
);

  logic [DBL_EXP_W-1:0] exp_f;
  logic [DBL_MAN_W-1:0] man_f;
  logic                 exp_max;
  logic                 exp_min;

  assign sign    = dbl[DBL_W-1];
  assign exp_f   = dbl[DBL_W-2 -: DBL_EXP_W];
  assign man_f   = dbl[DBL_MAN_W-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;

  always_comb begin
    if (exp_max)
      kind = (man_f == '0) ? K_INF : (man_f[DBL_MAN_W-1] ? K_QNAN : K_SNAN);
    else if (exp_min && man_f == '0)
      kind = K_ZERO;
    else
      kind = K_FINITE;
  end

  // a subnormal operand behaves as exponent field 1 without the hidden bit
  assign es      = $signed({2'b00, (exp_min ? DBL_EXP_W'(1) : exp_f)})
                   - EXP_S_W'(BIAS_GAP);
  assign sig     = {~exp_min, man_f};
  assign payload = man_f[DBL_MAN_W-2 -: SGL_MAN_W-1];
  assign den_in  = exp_min && (man_f != '0);

endmodule

// File: rtl/narrow_round.sv
module narrow_round
  import narrow_pkg::*;
(
  input  logic                      sign,
  input  rnd_e                      mode,
  input  logic signed [EXP_S_W-1:0] es,
  input  logic [SIG_W-1:0]          sig,
  output logic [SGL_W-2:0]          mag,
  output logic                      ovf,
  output logic                      tiny,
  output logic                      inexact
);

  logic [SH_W-1:0]      sh;
  logic [SGL_MAN_W:0]   kept;
  logic                 rbit;
  logic                 stk;
  logic [SIG_W-1:0]     low_mask;
  logic                 inc;
  logic [7:0]           base;
  logic [SGL_W-1:0]     sum;
  logic                 pre_ovf;
  logic                 post_ovf;

  // right shift that lines the significand up on the binary32 unit in the last place
  always_comb begin
    if (es >= EXP_S_W'(1))
      sh = SH_W'(NORM_SH);
    else if (es < -EXP_S_W'(MAX_SH - NORM_SH - 1))
      sh = SH_W'(MAX_SH);
    else
      sh = SH_W'(EXP_S_W'(NORM_SH + 1) - es);
  end

  assign kept     = (SGL_MAN_W + 1)'(sig >> sh);
  assign rbit     = 1'(sig >> (sh - SH_W'(1)));
  assign low_mask = (SIG_W'(1) << (sh - SH_W'(1))) - SIG_W'(1);
  assign stk      = |(sig & low_mask);
  assign inc      = round_up(mode, sign, kept[0], rbit, stk);

  // the hidden bit in kept lifts the exponent field by one, so the base is es minus one
  assign base     = (es >= EXP_S_W'(1) && es <= EXP_S_W'(254)) ? 8'(es - EXP_S_W'(1)) : 8'd0;
  assign sum      = {1'b0, base, {SGL_MAN_W{1'b0}}} + {8'd0, kept} + {31'd0, inc};

  assign pre_ovf  = es >= EXP_S_W'(255);
  assign post_ovf = sum[SGL_W-1:SGL_MAN_W] >= 9'd255;
  assign ovf      = pre_ovf | post_ovf;
  assign tiny     = es < EXP_S_W'(1);
  assign inexact  = rbit | stk;
  assign mag      = sum[SGL_W-2:0];

endmodule

// File: rtl/narrow_lane.sv
module narrow_lane
  import narrow_pkg::*;
(
  input  logic [DBL_W-1:0] dbl,
  input  rnd_e             mode,
  output logic [SGL_W-1:0] sgl,
  output flags_t           flg
);

  logic                      sign;
  kind_e                     kind;
  logic signed [EXP_S_W-1:0] es;
  logic [SIG_W-1:0]          sig;
  logic [SGL_MAN_W-2:0]      payload;
  logic                      den_in;
  logic [SGL_W-2:0]          mag;
  logic                      ovf;
  logic                      tiny;
  logic                      inexact;

  narrow_unpack u_unpack (
    .dbl     (dbl),
    .sign    (sign),
    .kind    (kind),
    .es      (es),
    .sig     (sig),
    .payload (payload),
    .den_in  (den_in)
  );

  narrow_round u_round (
    .sign    (sign),
    .mode    (mode),
    .es      (es),
    .sig     (sig),
    .mag     (mag),
    .ovf     (ovf),
    .tiny    (tiny),
    .inexact (inexact)
  );

  always_comb begin
    flg = '0;
    case (kind)
      K_ZERO: sgl = {sign, {(SGL_W-1){1'b0}}};
      K_INF:  sgl = {sign, 8'hFF, {SGL_MAN_W{1'b0}}};
      K_QNAN: sgl = {sign, 8'hFF, 1'b1, payload};
      K_SNAN: begin
        sgl     = {sign, 8'hFF, 1'b1, payload};
        flg.inv = 1'b1;
      end
      default: begin
        flg.den = den_in;
        if (ovf) begin
          flg.ovf = 1'b1;
          flg.pre = 1'b1;
          sgl = ovf_to_inf(mode, sign) ? {sign, 8'hFF, {SGL_MAN_W{1'b0}}}
                                       : {sign, 8'hFE, {SGL_MAN_W{1'b1}}};
        end else begin
          flg.pre = inexact;
          flg.unf = tiny & inexact;
          sgl     = {sign, mag};
        end
      end
    endcase
  end

endmodule

// File: rtl/narrow_pair_cvt.sv
module narrow_pair_cvt
  import narrow_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [LANES*DBL_W-1:0] in_pair,
  input  logic [1:0]             rnd_mode,
  output logic                   out_valid,
  output logic [LANES*DBL_W-1:0] out_pair,
  output logic                   flag_invalid,
  output logic                   flag_denorm,
  output logic                   flag_overflow,
  output logic                   flag_underflow,
  output logic                   flag_inexact
);

  localparam int PAIR_W = LANES * DBL_W;
  localparam int LOW_W  = LANES * SGL_W;

  rnd_e                         mode_e;
  logic [LANES-1:0][SGL_W-1:0]  lane_res;
  flags_t [LANES-1:0]           lane_flg;
  flags_t                       any_flg;
  logic [PAIR_W-1:0]            pair_next;
  flags_t                       flg_q;

  assign mode_e = rnd_e'(rnd_mode);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    narrow_lane u_lane (
      .dbl  (in_pair[g*DBL_W +: DBL_W]),
      .mode (mode_e),
      .sgl  (lane_res[g]),
      .flg  (lane_flg[g])
    );
  end

  always_comb begin
    any_flg = '0;
    for (int i = 0; i < LANES; i++) any_flg = any_flg | lane_flg[i];
  end

  assign pair_next = {{(PAIR_W-LOW_W){1'b0}}, lane_res};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pair  <= '0;
      flg_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pair <= pair_next;
        flg_q    <= any_flg;
      end
    end
  end

  assign flag_invalid   = flg_q.inv;
  assign flag_denorm    = flg_q.den;
  assign flag_overflow  = flg_q.ovf;
  assign flag_underflow = flg_q.unf;
  assign flag_inexact   = flg_q.pre;

  // R1
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_pair[PAIR_W-1:LOW_W] == '0);

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_pair) && $stable(flg_q)));

  // R5
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_overflow |-> flag_inexact);

  // R6
  unf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_underflow |-> flag_inexact);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R4
    nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_pair[g*SGL_W+SGL_MAN_W +: 8] == 8'hFF && out_pair[g*SGL_W +: SGL_MAN_W] != '0)
        |-> out_pair[g*SGL_W+SGL_MAN_W-1]);
  end

endmodule

// File: tb/test_narrow_pair_cvt.sv
module test_narrow_pair_cvt;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] in_pair = '0;
  logic [1:0]   rnd_mode = 2'b00;
  logic         out_valid;
  logic [127:0] out_pair;
  logic         flag_invalid, flag_denorm, flag_overflow, flag_underflow, flag_inexact;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  narrow_pair_cvt i_narrow_pair_cvt (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_pair        (in_pair),
    .rnd_mode       (rnd_mode),
    .out_valid      (out_valid),
    .out_pair       (out_pair),
    .flag_invalid   (flag_invalid),
    .flag_denorm    (flag_denorm),
    .flag_overflow  (flag_overflow),
    .flag_underflow (flag_underflow),
    .flag_inexact   (flag_inexact)
  );

  // reference narrowing: {result[31:0], flags {inv,den,ovf,unf,pre}}
  function automatic logic [36:0] ref_cvt(logic [63:0] d, logic [1:0] mode);
    logic s, den, rb, st, up, lost;
    int e, e2, msb, lg, qe, sh, biased;
    logic [52:0] sig, q;
    logic [31:0] r;
    logic [4:0] f;
    s = d[63];
    e = int'(d[62:52]);
    f = '0;
    if (e == 2047) begin
      if (d[51:0] == '0) r = {s, 8'hFF, 23'h0};
      else begin
        r = {s, 8'hFF, 1'b1, d[50:29]};
        f[4] = ~d[51];
      end
      return {r, f};
    end
    if (e == 0 && d[51:0] == '0) return {{s, 31'h0}, 5'h0};
    den = (e == 0);
    sig = {~den, d[51:0]};
    e2 = den ? -1074 : e - 1075;
    msb = 0;
    for (int i = 0; i < 53; i++) if (sig[i]) msb = i;
    lg = msb + e2;
    qe = lg - 23;
    if (qe < -149) qe = -149;
    sh = qe - e2;
    q = sig; rb = 1'b0; st = 1'b0;
    if (sh > 60) begin
      st = |sig;
      q = '0;
    end else begin
      for (int i = 0; i < sh; i++) begin
        st = st | rb;
        rb = q[0];
        q = q >> 1;
      end
    end
    lost = rb | st;
    case (mode)
      2'b00: up = rb & (st | q[0]);
      2'b01: up = lost & s;
      2'b10: up = lost & ~s;
      default: up = 1'b0;
    endcase
    q = q + 53'(up);
    if (q[24]) begin
      q = q >> 1;
      qe = qe + 1;
    end
    f[0] = lost;
    f[3] = den;
    if (lg < -126 && lost) f[1] = 1'b1;
    if (q >= 53'h800000) begin
      biased = qe + 150;
      if (biased >= 255) begin
        f[2] = 1'b1;
        f[0] = 1'b1;
        f[1] = 1'b0;
        if (mode == 2'b00 || (mode == 2'b10 && !s) || (mode == 2'b01 && s))
          r = {s, 8'hFF, 23'h0};
        else
          r = {s, 8'hFE, 23'h7FFFFF};
      end else begin
        r = {s, 8'(biased), q[22:0]};
      end
    end else begin
      r = {s, 8'h00, q[22:0]};
    end
    return {r, f};
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // present one operand pair, then compare result and flags one clock later
  task automatic run_vec(string tag, logic [63:0] lo, logic [63:0] hi, logic [1:0] mode);
    logic [36:0] a, b;
    @(negedge clk);
    in_valid = 1'b1;
    in_pair  = {hi, lo};
    rnd_mode = mode;
    a = ref_cvt(lo, mode);
    b = ref_cvt(hi, mode);
    @(negedge clk);
    check({tag, " R1 data"}, out_pair, {64'h0, b[36:5], a[36:5]});
    check({tag, " R10 flags"},
          {123'h0, flag_invalid, flag_denorm, flag_overflow, flag_underflow, flag_inexact},
          {123'h0, a[4:0] | b[4:0]});
    check({tag, " R2 valid"}, {127'h0, out_valid}, 128'h1);
  endtask

  function automatic logic [63:0] rand_dbl();
    logic [63:0] d;
    logic [10:0] ex;
    int pick;
    d = {$urandom, $urandom};
    pick = int'($urandom % 8);
    if (pick < 5) ex = 11'(836 + ($urandom % 332));
    else if (pick == 5) ex = 11'($urandom % 4);
    else ex = d[62:52];
    d[62:52] = ex;
    case ($urandom % 4)
      0: d[28:0] = 29'h10000000;
      1: d[28:0] = 29'h1FFFFFFF;
      default: ;
    endcase
    return d;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset data", out_pair, 128'h0);
    check("R11 reset flags",
          {123'h0, flag_invalid, flag_denorm, flag_overflow, flag_underflow, flag_inexact}, 128'h0);
    check("R11 reset valid", {127'h0, out_valid}, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after release", {out_pair[127:1], out_valid}, 128'h0);

    // R1 lane placement with exact values
    run_vec("R1 place", 64'h3FF0000000000000, 64'hC004000000000000, 2'b00);
    check("R1 lane values", out_pair, {64'h0, 32'hC0200000, 32'h3F800000});

    // R3 halfway ties and each direction
    for (int m = 0; m < 4; m++) begin
      run_vec("R3 tie even", 64'h3FF0000010000000, 64'hBFF0000030000000, 2'(m));
      run_vec("R3 above half", 64'h3FF0000010000001, 64'hBFF000000FFFFFFF, 2'(m));
    end
    // R5 overflow from large value and by rounding, both signs, every mode
    for (int m = 0; m < 4; m++) begin
      run_vec("R5 big", 64'h7FEFFFFFFFFFFFFF, 64'hC7F0000000000000, 2'(m));
      run_vec("R5 carry", 64'h47EFFFFFF0000000, 64'hC7EFFFFFF0000000, 2'(m));
    end
    // R4 NaNs
    run_vec("R4 nan", 64'h7FF0000000000001, 64'hFFF8000000000000, 2'b00);
    check("R4 nan values", out_pair, {64'h0, 32'hFFC00000, 32'h7FC00000});
    check("R4 invalid", {127'h0, flag_invalid}, 128'h1);
    run_vec("R4 quiet only", 64'h7FFC0000E0000000, 64'h3FF0000000000000, 2'b11);
    check("R4 quiet no invalid", {127'h0, flag_invalid}, 128'h0);
    // R8 zeros and infinities
    run_vec("R8 specials", 64'h8000000000000000, 64'h7FF0000000000000, 2'b01);
    check("R8 specials values", out_pair, {64'h0, 32'h7F800000, 32'h80000000});
    check("R8 no flags",
          {123'h0, flag_invalid, flag_denorm, flag_overflow, flag_underflow, flag_inexact}, 128'h0);
    // R7 and R6 subnormal operand, tiny results, exact tiny, carry to normal
    for (int m = 0; m < 4; m++) begin
      run_vec("R7 den in", 64'h0000000000000001, 64'h800FFFFFFFFFFFFF, 2'(m));
      run_vec("R6 tiny", 64'h36A0000000000000, 64'h380FFFFFF0000000, 2'(m));
      run_vec("R6 half tiny", 64'h3690000000000000, 64'hB6A8000000000000, 2'(m));
    end
    run_vec("R6 exact tiny", 64'h36A0000000000000, 64'h36B0000000000000, 2'b00);
    check("R6 exact no unf", {126'h0, flag_underflow, flag_inexact}, 128'h0);
    // R9 inexact from a plain normal value
    run_vec("R9 inexact", 64'h3FB999999999999A, 64'h3FF0000000000000, 2'b11);
    check("R9 inexact set", {127'h0, flag_inexact}, 128'h1);

    // R2 hold while idle
    held = out_pair;
    @(negedge clk);
    in_valid = 1'b0;
    in_pair  = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk);
    check("R2 idle valid", {127'h0, out_valid}, 128'h0);
    check("R2 idle hold", out_pair, held);
    check("R2 idle flags", {127'h0, flag_inexact}, 128'h1);

    // R3 R6 random mix near the range edges
    for (int k = 0; k < 600; k++) begin
      run_vec("R3 random", rand_dbl(), rand_dbl(), 2'($urandom % 4));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule